// File: doc/BRIEF.md
# Two-Thread Stage Flow Controller with Skid Buffers

This block handles flow control for one middle stage of a processor front end that runs two hardware threads. Each cycle up to W instruction slots arrive from the stage above. Each slot carries a valid bit, a thread tag, a sequence number, an opaque payload and a "squashed" mark. The block sorts the slots to their thread by tag and forwards them to that thread's output lane of W slots. Slot positions and program order are kept.

Each thread has its own five-state status and its own skid buffer. When the stage below stalls a thread, that thread's arriving slots are parked in its skid buffer. Once the stall lifts, the buffer is drained ahead of any new input. Toward the stage above, the block raises a one-cycle block flag when a thread starts to back up. It raises a one-cycle unblock flag once the backlog is gone. Each flag is sent once per change of that condition. A squash from a later stage wipes out everything the block holds for that thread.

Top module: `stage_flow_ctl`

## Requirements
- R1: After reset both threads report status idle (code 0). No output slot is valid, `block_o`, `unblock_o` and `active_o` are low.
- R2: In a cycle where `stall_i[t]` is high and `squash_i[t]` is low, nothing is forwarded on lane t. That cycle's slots for thread t enter its skid buffer in slot order, and the status reads blocked (code 2) from the next cycle.
- R3: `block_o[t]` pulses for one cycle, in the cycle after the first stalled cycle of a backlog. Further stalled cycles before the matching unblock raise no new pulse.
- R4: A blocked thread whose stall has dropped forwards nothing that cycle and reads unblocking (code 3) in the next. While unblocking it forwards up to W buffered slots per cycle, oldest first, on slots 0 upward. Slots arriving meanwhile are queued behind the buffered ones.
- R5: In the cycle after an unblocking thread's buffer empties, `unblock_o[t]` pulses and the status reads running (code 1). If a stall arrives in the cycle the buffer would have emptied, no pop happens and neither flag is sent. The status returns to blocked.
- R6: A squash for thread t drops its buffered slots and its slots in the same cycle. The status reads squashing (code 4) next, and running after the next squash-free cycle. If upstream had been told blocked, `unblock_o[t]` pulses in the cycle after the squash.
- R7: In idle, running or squashing without stall, input slot i holding a valid slot with tag t and no squashed mark appears on lane t slot i in the same cycle. A slot carrying the squashed mark is never forwarded.
- R8: `active_o` is high in a cycle when any thread is unblocking or any input slot is valid, and low otherwise.
- R9: Each skid buffer holds 2×W slots. This covers two full cycles of input, the stall cycle and the cycle the block flag is visible, with no loss.
- R10: A stall, block or squash on one thread leaves the other thread's forwarding and flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | W | Input slot valid |
| in_tid_i | input | W×TID_W | Thread tag per slot |
| in_seq_i | input | W×SEQ_W | Sequence number per slot |
| in_pay_i | input | W×PAY_W | Opaque payload per slot |
| in_sqd_i | input | W | Slot already marked squashed |
| stall_i | input | NT | Downstream stall per thread |
| squash_i | input | NT | Squash from a later stage per thread |
| out_vld_o | output | NT×W | Forwarded slot valid, per thread lane |
| out_seq_o | output | NT×W×SEQ_W | Forwarded sequence numbers |
| out_pay_o | output | NT×W×PAY_W | Forwarded payloads |
| block_o | output | NT | One-cycle block flag to upstream |
| unblock_o | output | NT | One-cycle unblock flag to upstream |
| status_o | output | NT×3 | Per-thread status code |
| active_o | output | 1 | Stage has work this cycle |

## Verification
The bench goes after ordering across a stall. It fills a buffer to exactly 2×W and then injects fresh slots during the drain. A design that lets new input overtake buffered slots, or that wraps its pointers wrongly, shows up as a sequence mismatch in the scoreboard.

It also checks the cycle where a stall reappears just as the buffer would empty. A design that still pops there or sends an unblock would hand upstream a flag pair that contradicts the real state.

A squash on a blocked thread is checked as well. A design that keeps stale slots would emit them later. One that forgets the unblock flag would leave upstream frozen. Mixed-tag inputs with squashed marks catch routing by position instead of by tag.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } tstat_e;
endpackage

// File: rtl/lane_skid.sv
module lane_skid #(
  parameter int W     = 4,
  parameter int DW    = 48,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(W + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  push_en_i,
  input  logic [W-1:0]          push_vld_i,
  input  logic [W-1:0][DW-1:0]  push_dat_i,
  input  logic [NW-1:0]         pop_n_i,
  output logic [CW-1:0]         cnt_o,
  output logic [NW-1:0]         npush_o,
  output logic [W-1:0][DW-1:0]  head_dat_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  int            off [W];

  function automatic logic [PW-1:0] wrap(input int a);
    return PW'(a % DEPTH);
  endfunction

  // compact valid slots: offset of each slot among the pushed ones
  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < W; i++) begin
      off[i] = acc;
      if (push_vld_i[i]) acc = acc + 1;
    end
    npush_o = NW'(acc);
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < W; i++) begin
      if (push_en_i && !flush_i && push_vld_i[i] &&
          (int'(cnt_q) - int'(pop_n_i) + off[i] < DEPTH))
        mem[wrap(int'(head_q) + int'(cnt_q) + off[i])] <= push_dat_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      int nxt;
      nxt = int'(cnt_q) - int'(pop_n_i) + (push_en_i ? int'(npush_o) : 0);
      if (nxt > DEPTH) nxt = DEPTH;
      head_q <= wrap(int'(head_q) + int'(pop_n_i));
      cnt_q  <= CW'(nxt);
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) head_dat_o[i] = mem[wrap(int'(head_q) + i)];
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_en_i && !flush_i) |-> (int'(cnt_q) - int'(pop_n_i) + int'(npush_o) <= DEPTH)); // R9
  AST_POP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(cnt_q)); // R4
endmodule

// File: rtl/thread_ctl.sv
module thread_ctl
  import sfc_pkg::*;
#(
  parameter int W     = 4,
  parameter int DW    = 48,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          in_vld_i,
  input  logic [W-1:0][DW-1:0]  in_dat_i,
  input  logic                  stall_i,
  input  logic                  squash_i,
  output logic [W-1:0]          out_vld_o,
  output logic [W-1:0][DW-1:0]  out_dat_o,
  output logic                  block_o,
  output logic                  unblock_o,
  output logic [2:0]            status_o
);
  tstat_e               st_q, st_d;
  logic                 up_blk_q;
  logic                 blk_q, unb_q;
  logic                 blk_evt, unb_evt;
  logic                 flush, push_en, fwd;
  logic [NW-1:0]        pop_n, npush;
  logic [CW-1:0]        cnt;
  logic [W-1:0][DW-1:0] head_dat;

  lane_skid #(.W(W), .DW(DW), .DEPTH(DEPTH)) u_skid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .push_en_i  (push_en),
    .push_vld_i (in_vld_i),
    .push_dat_i (in_dat_i),
    .pop_n_i    (pop_n),
    .cnt_o      (cnt),
    .npush_o    (npush),
    .head_dat_o (head_dat)
  );

  always_comb begin
    st_d    = st_q;
    flush   = 1'b0;
    push_en = 1'b0;
    fwd     = 1'b0;
    pop_n   = '0;
    blk_evt = 1'b0;
    unb_evt = 1'b0;
    if (squash_i) begin
      flush   = 1'b1;
      st_d    = ST_SQ;
      unb_evt = up_blk_q;
    end else if (stall_i) begin
      st_d    = ST_BLK;
      push_en = 1'b1;
      blk_evt = !up_blk_q;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          fwd = 1'b1;
          if (|in_vld_i) st_d = ST_RUN;
        end
        ST_RUN, ST_SQ: begin
          fwd  = 1'b1;
          st_d = ST_RUN;
        end
        ST_BLK: begin
          push_en = 1'b1;
          st_d    = ST_UNB;
        end
        ST_UNB: begin
          push_en = 1'b1;
          pop_n   = (int'(cnt) > W) ? NW'(W) : NW'(cnt);
          if (int'(cnt) - int'(pop_n) + int'(npush) == 0) begin
            st_d    = ST_RUN;
            unb_evt = up_blk_q;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (fwd) begin
        out_vld_o[i] = in_vld_i[i];
        out_dat_o[i] = in_dat_i[i];
      end else begin
        out_vld_o[i] = (i < int'(pop_n));
        out_dat_o[i] = head_dat[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      up_blk_q <= 1'b0;
      blk_q    <= 1'b0;
      unb_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      blk_q    <= blk_evt;
      unb_q    <= unb_evt;
      if (blk_evt)      up_blk_q <= 1'b1;
      else if (unb_evt) up_blk_q <= 1'b0;
    end
  end

  assign block_o   = blk_q;
  assign unblock_o = unb_q;
  assign status_o  = st_q;

  AST_STALL_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !squash_i) |=> (st_q == ST_BLK)); // R2
  AST_BLK_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> !block_o); // R3
  AST_UNB_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblock_o |-> (cnt == '0)); // R5
  AST_SQ_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> (cnt == '0 && st_q == ST_SQ)); // R6
  AST_BLK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BLK) |-> (out_vld_o == '0)); // R4
endmodule

// File: rtl/stage_flow_ctl.sv
module stage_flow_ctl
  import sfc_pkg::*;
#(
  parameter int NT    = 2,
  parameter int W     = 4,
  parameter int SEQ_W = 16,
  parameter int PAY_W = 32,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int DW    = SEQ_W + PAY_W,
  localparam int DEPTH = 2 * W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [W-1:0]                       in_vld_i,
  input  logic [W-1:0][TID_W-1:0]            in_tid_i,
  input  logic [W-1:0][SEQ_W-1:0]            in_seq_i,
  input  logic [W-1:0][PAY_W-1:0]            in_pay_i,
  input  logic [W-1:0]                       in_sqd_i,
  input  logic [NT-1:0]                      stall_i,
  input  logic [NT-1:0]                      squash_i,
  output logic [NT-1:0][W-1:0]               out_vld_o,
  output logic [NT-1:0][W-1:0][SEQ_W-1:0]    out_seq_o,
  output logic [NT-1:0][W-1:0][PAY_W-1:0]    out_pay_o,
  output logic [NT-1:0]                      block_o,
  output logic [NT-1:0]                      unblock_o,
  output logic [NT-1:0][2:0]                 status_o,
  output logic                               active_o
);
  logic [W-1:0][DW-1:0]          in_dat;
  logic [NT-1:0][W-1:0]          lane_vld;
  logic [NT-1:0][W-1:0][DW-1:0]  lane_dat;
  logic [NT-1:0]                 unb_st;

  for (genvar i = 0; i < W; i++) begin : g_pack
    assign in_dat[i] = {in_seq_i[i], in_pay_i[i]};
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    for (genvar i = 0; i < W; i++) begin : g_slot
      assign lane_vld[t][i]  = in_vld_i[i] && (in_tid_i[i] == TID_W'(t)) && !in_sqd_i[i];
      assign out_seq_o[t][i] = lane_dat[t][i][DW-1:PAY_W];
      assign out_pay_o[t][i] = lane_dat[t][i][PAY_W-1:0];
    end

    thread_ctl #(.W(W), .DW(DW), .DEPTH(DEPTH)) u_thr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_vld_i  (lane_vld[t]),
      .in_dat_i  (in_dat),
      .stall_i   (stall_i[t]),
      .squash_i  (squash_i[t]),
      .out_vld_o (out_vld_o[t]),
      .out_dat_o (lane_dat[t]),
      .block_o   (block_o[t]),
      .unblock_o (unblock_o[t]),
      .status_o  (status_o[t])
    );

    assign unb_st[t] = (status_o[t] == ST_UNB);
  end

  assign active_o = (|unb_st) || (|in_vld_i);

  AST_ACTIVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (out_vld_o == '0)); // R8
endmodule

// File: tb/stage_flow_ctl_test.sv
module stage_flow_ctl_test;
  localparam int NT = 2, W = 4, SEQ_W = 16, PAY_W = 32, TID_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]                    in_vld = '0;
  logic [W-1:0][TID_W-1:0]         in_tid = '0;
  logic [W-1:0][SEQ_W-1:0]         in_seq = '0;
  logic [W-1:0][PAY_W-1:0]         in_pay = '0;
  logic [W-1:0]                    in_sqd = '0;
  logic [NT-1:0]                   stall = '0, squash = '0;
  logic [NT-1:0][W-1:0]            out_vld;
  logic [NT-1:0][W-1:0][SEQ_W-1:0] out_seq;
  logic [NT-1:0][W-1:0][PAY_W-1:0] out_pay;
  logic [NT-1:0]                   blk, unb;
  logic [NT-1:0][2:0]              status;
  logic                            active;

  int checks = 0, errors = 0, seq_ctr = 100;
  int exp_q0[$];
  int exp_q1[$];

  always #10 clk = ~clk;

  stage_flow_ctl #(.NT(NT), .W(W), .SEQ_W(SEQ_W), .PAY_W(PAY_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_tid_i(in_tid), .in_seq_i(in_seq),
    .in_pay_i(in_pay), .in_sqd_i(in_sqd), .stall_i(stall), .squash_i(squash),
    .out_vld_o(out_vld), .out_seq_o(out_seq), .out_pay_o(out_pay), .block_o(blk),
    .unblock_o(unb), .status_o(status), .active_o(active));

  function automatic logic [PAY_W-1:0] pay_of(input int s, input int t);
    return 32'hA5C30000 ^ PAY_W'(s * 7) ^ PAY_W'(t << 12);
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < NT; t++) begin
        for (int i = 0; i < W; i++) begin
          if (out_vld[t][i]) begin
            int e;
            checks++;
            if (t == 0 ? exp_q0.size() == 0 : exp_q1.size() == 0) begin
              errors++;
              $display("FAIL R7 lane %0d slot %0d: got seq %0d expected none", t, i, out_seq[t][i]);
            end else begin
              e = (t == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
              if (int'(out_seq[t][i]) != e || out_pay[t][i] != pay_of(e, t)) begin
                errors++;
                $display("FAIL R4 lane %0d slot %0d: got seq %0d expected %0d", t, i, out_seq[t][i], e);
              end
            end
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    in_vld = '0; in_sqd = '0; stall = '0; squash = '0;
  endtask

  task automatic mid();
    #8;
  endtask

  task automatic put(input int i, input int t, input bit sq);
    in_vld[i] = 1'b1;
    in_tid[i] = TID_W'(t);
    in_seq[i] = SEQ_W'(seq_ctr);
    in_pay[i] = pay_of(seq_ctr, t);
    in_sqd[i] = sq;
    if (!sq) begin
      if (t == 0) exp_q0.push_back(seq_ctr);
      else exp_q1.push_back(seq_ctr);
    end
    seq_ctr++;
  endtask

  task automatic kill(input int t);
    squash[t] = 1'b1;
    if (t == 0) exp_q0.delete();
    else exp_q1.delete();
  endtask

  initial begin
    #10_000_000;
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(); mid();
    chk("R1 status0", status[0], 0); chk("R1 status1", status[1], 0);
    chk("R1 flags", {blk, unb}, 0); chk("R1 active", active, 0); chk("R1 out", out_vld, 0);
    // R7 plain forwarding
    step(); for (int i = 0; i < W; i++) put(i, 0, 0); mid();
    chk("R7 lane0 all", out_vld[0], 4'hF); chk("R8 active on input", active, 1);
    step(); mid(); chk("R7 status run", status[0], 1);
    // R7 tag routing and squashed marks
    step(); put(0, 1, 0); put(1, 0, 1); put(2, 1, 0); put(3, 0, 0); mid();
    chk("R7 lane0 mixed", out_vld[0], 4'b1000); chk("R7 lane1 mixed", out_vld[1], 4'b0101);
    // R2/R3/R9 stall with two full cycles
    step(); stall[0] = 1; for (int i = 0; i < W; i++) put(i, 0, 0); mid();
    chk("R2 no fwd when stalled", out_vld[0], 0);
    step(); stall[0] = 1; for (int i = 0; i < W; i++) put(i, 0, 0); mid();
    chk("R2 status blk", status[0], 2); chk("R3 block pulse", blk[0], 1);
    step(); stall[0] = 1; put(0, 1, 0); put(1, 1, 0); mid();
    chk("R3 block once", blk[0], 0); chk("R10 lane1 flows", out_vld[1], 4'b0011);
    chk("R10 no flag thr1", {blk[1], unb[1]}, 0);
    // R4 drain
    step(); mid(); chk("R4 transition quiet", out_vld[0], 0); chk("R4 still blk", status[0], 2);
    step(); put(0, 0, 0); put(1, 0, 0); mid();
    chk("R4 status unb", status[0], 3); chk("R4 pop W", out_vld[0], 4'hF);
    step(); mid(); chk("R8 active unb", active, 1); chk("R4 pop W 2", out_vld[0], 4'hF);
    step(); mid(); chk("R4 late pop", out_vld[0], 4'b0011); chk("R5 no early unblock", unb[0], 0);
    step(); mid(); chk("R5 unblock pulse", unb[0], 1); chk("R5 status run", status[0], 1);
    step(); mid(); chk("R5 unblock once", unb[0], 0); chk("R8 active low", active, 0);
    // R5 restall in emptying cycle
    step(); stall[0] = 1; put(0, 0, 0); put(1, 0, 0); mid();
    step(); mid(); chk("R3 block again", blk[0], 1);
    step(); stall[0] = 1; mid(); chk("R5 unb before restall", status[0], 3); chk("R5 no pop on stall", out_vld[0], 0);
    step(); mid(); chk("R5 back blk", status[0], 2); chk("R5 no flags", {blk[0], unb[0]}, 0);
    step(); mid(); chk("R5 drain", out_vld[0], 4'b0011);
    step(); mid(); chk("R5 late unblock", unb[0], 1);
    // R6 squash on blocked thread 1
    step(); stall[1] = 1; put(0, 1, 0); put(1, 1, 0); put(2, 1, 0); mid();
    step(); put(0, 1, 0); put(1, 1, 0); kill(1); mid();
    chk("R6 no out on squash", out_vld[1], 0); chk("R3 block thr1", blk[1], 1);
    chk("R10 thr0 untouched", status[0], 1);
    step(); put(0, 1, 0); mid();
    chk("R6 status sq", status[1], 4); chk("R6 unblock on squash", unb[1], 1);
    chk("R6 fwd after squash", out_vld[1], 4'b0001);
    step(); mid(); chk("R6 back run", status[1], 1);
    step(); mid();
    chk("R6 nothing stale thr0", exp_q0.size(), 0); chk("R6 nothing stale thr1", exp_q1.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule